// File: doc/BRIEF.md
# System Reset Control Port

This block is a byte-wide register that sits on a simple port-I/O bus and answers at one fixed I/O address. Software uses it to ask the platform for a system reset and to choose which kind of reset is wanted. A write that sets the trigger bit (bit 2) raises a request pulse for one clock and leaves the stored byte as it was. Any other write to the port keeps only the reset-type bit (bit 1) and clears every other bit.

The block produces only two things: the request pulse and the latched reset-type level. Logic elsewhere on the chip turns these into the actual reset sequence. Reads at the port return the stored byte, with bit 2 always zero. Accesses to any other I/O address leave the register unchanged and do not drive read data.

Top module: `sys_rst_ctrl`

## Requirements
- R1: Only accesses whose full address equals 0xCF9 reach the register. A write to any other address, including one that differs from 0xCF9 only in an upper address bit, leaves the stored value unchanged.
- R2: A write to 0xCF9 with bit 2 of the write data set drives `sys_rst_req_o` high in the cycle after the write strobe is sampled.
- R3: A write to 0xCF9 with bit 2 set leaves the stored reset-type bit unchanged, whatever the other data bits hold.
- R4: A write to 0xCF9 with bit 2 clear stores bit 1 of the write data. All other bits of the stored byte read back as zero, and bit 2 always reads back as zero.
- R5: While `io_rd_i` is high and the address is 0xCF9, `io_rdata_o` returns the stored byte in the same cycle, with bit 1 carrying the reset type, and `io_rdata_vld_o` is high.
- R6: A read at any other address, or no read at all, gives `io_rdata_o` = 0 and `io_rdata_vld_o` = 0.
- R7: While `rst_ni` is low, the stored byte is zero and `sys_rst_req_o` is low. This also holds when reset is asserted in the middle of operation.
- R8: `sys_rst_req_o` is high for exactly one cycle per triggering write. It is low in any cycle that does not follow a triggering write, so back-to-back triggering writes give one pulse each.
- R9: `rst_type_o` always equals the stored reset-type bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_addr_i | input | 16 | I/O port address |
| io_wr_i | input | 1 | Write strobe, one access per cycle it is high |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, zero when the port is not selected |
| io_rdata_vld_o | output | 1 | High when this block drives read data |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| rst_type_o | output | 1 | Latched reset-type bit |

## Verification
The embedded assertions check on every cycle that:
- a request pulse only ever follows a triggering write;
- a triggering write or a missed address keeps the reset type stable;
- a storing write captures bit 1;
- unselected reads return zero, and bit 2 never reads back as one.

Only the bench scenarios can show the rest. These include the exact pulse count for back-to-back triggers, aliasing on upper address bits, readback across mixed write sequences, and the register clearing when reset is asserted in the middle of operation.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned RSTCTL_ADDR_W   = 16;
  localparam int unsigned RSTCTL_DATA_W   = 8;
  localparam logic [RSTCTL_ADDR_W-1:0] RSTCTL_PORT = 16'hCF9;
  localparam int unsigned RSTCTL_TRIG_BIT = 2;
  localparam int unsigned RSTCTL_TYPE_BIT = 1;

  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
  } rstctl_sel_t;
endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
  import rstctl_pkg::*;
#(
  parameter int unsigned ADDR_W = RSTCTL_ADDR_W,
  parameter logic [ADDR_W-1:0] PORT = RSTCTL_PORT
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output rstctl_sel_t       sel_o
);
  logic match;

  // full-width compare: no aliasing on upper address bits
  assign match        = (addr_i == PORT);
  assign sel_o.wr_hit = wr_i & match;
  assign sel_o.rd_hit = rd_i & match;
endmodule

// File: rtl/rstctl_core.sv
module rstctl_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_hit_i,
  input  logic trig_i,
  input  logic type_i,
  output logic req_o,
  output logic type_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o    <= 1'b0;
      type_q_o <= 1'b0;
    end else begin
      req_o <= wr_hit_i & trig_i;
      // trigger writes leave storage untouched
      if (wr_hit_i && !trig_i) type_q_o <= type_i;
    end
  end

  AST_REQ_NEEDS_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(wr_hit_i && trig_i)); // R8
  AST_TRIG_KEEPS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && trig_i) |=> $stable(type_q_o)); // R3
  AST_STORE_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && !trig_i) |=> (type_q_o == $past(type_i))); // R4
endmodule

// File: rtl/rstctl_rdmux.sv
module rstctl_rdmux #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned TYPE_BIT = 1
) (
  input  logic              rd_hit_i,
  input  logic              type_q_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              vld_o
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == TYPE_BIT) begin : g_type
      assign rdata_o[i] = rd_hit_i & type_q_i;
    end else begin : g_zero
      assign rdata_o[i] = 1'b0;
    end
  end
  assign vld_o = rd_hit_i;
endmodule

// File: rtl/sys_rst_ctrl.sv
module sys_rst_ctrl
  import rstctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = RSTCTL_ADDR_W,
  parameter int unsigned DATA_W   = RSTCTL_DATA_W,
  parameter logic [ADDR_W-1:0] PORT = RSTCTL_PORT,
  parameter int unsigned TRIG_BIT = RSTCTL_TRIG_BIT,
  parameter int unsigned TYPE_BIT = RSTCTL_TYPE_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              io_rdata_vld_o,
  output logic              sys_rst_req_o,
  output logic              rst_type_o
);
  rstctl_sel_t sel;
  logic        type_q;
  logic        unused_wdata;

  assign unused_wdata = ^io_wdata_i;

  rstctl_decode #(.ADDR_W(ADDR_W), .PORT(PORT)) u_decode (
    .addr_i (io_addr_i),
    .wr_i   (io_wr_i),
    .rd_i   (io_rd_i),
    .sel_o  (sel)
  );

  rstctl_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_hit_i (sel.wr_hit),
    .trig_i   (io_wdata_i[TRIG_BIT]),
    .type_i   (io_wdata_i[TYPE_BIT]),
    .req_o    (sys_rst_req_o),
    .type_q_o (type_q)
  );

  rstctl_rdmux #(.DATA_W(DATA_W), .TYPE_BIT(TYPE_BIT)) u_rdmux (
    .rd_hit_i (sel.rd_hit),
    .type_q_i (type_q),
    .rdata_o  (io_rdata_o),
    .vld_o    (io_rdata_vld_o)
  );

  assign rst_type_o = type_q;

  AST_MISS_KEEPS_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_addr_i == PORT) |=> $stable(rst_type_o)); // R1
  AST_REQ_FROM_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> $past(io_wr_i && io_addr_i == PORT && io_wdata_i[TRIG_BIT])); // R2
  AST_RD_MISS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_rd_i && io_addr_i == PORT) |-> (io_rdata_o == '0 && !io_rdata_vld_o)); // R6
  AST_TRIG_BIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rdata_o[TRIG_BIT]); // R4
  AST_RD_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rdata_vld_o |-> (io_rdata_o[TYPE_BIT] == rst_type_o)); // R5
endmodule

// File: tb/sys_rst_ctrl_bench.sv
module sys_rst_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        vld;
  logic        req;
  logic        rtype;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string scen = "R7";

  logic m_type = 1'b0;
  logic m_req  = 1'b0;

  always #2.5 clk = ~clk;

  sys_rst_ctrl u_sys_rst_ctrl (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .io_addr_i      (addr),
    .io_wr_i        (wr),
    .io_rd_i        (rd),
    .io_wdata_i     (wdata),
    .io_rdata_o     (rdata),
    .io_rdata_vld_o (vld),
    .sys_rst_req_o  (req),
    .rst_type_o     (rtype)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_type = 1'b0;
      m_req  = 1'b0;
    end else begin
      m_req = wr && addr == 16'hCF9 && wdata[2];
      if (wr && addr == 16'hCF9 && !wdata[2]) m_type = wdata[1];
    end
  end

  always @(negedge clk) begin
    logic       sel;
    logic [7:0] exp_rd;
    sel    = rd && addr == 16'hCF9;
    exp_rd = sel ? {6'b0, m_type, 1'b0} : 8'h00;
    vectors++;
    if (req !== m_req) begin
      miscompares++;
      $display("FAIL %s (R2/R8) req act=%b exp=%b", scen, req, m_req);
    end
    if (rtype !== m_type) begin
      miscompares++;
      $display("FAIL %s (R9) type act=%b exp=%b", scen, rtype, m_type);
    end
    if (rdata !== exp_rd || vld !== sel) begin
      miscompares++;
      $display("FAIL %s (%s) rdata act=%h/%b exp=%h/%b", scen, sel ? "R5" : "R6",
               rdata, vld, exp_rd, sel);
    end
  end

  task automatic drive(input logic [15:0] a, input logic w, input logic r,
                       input logic [7:0] d);
    @(posedge clk);
    #1;
    addr = a; wr = w; rd = r; wdata = d;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    drive(a, 1'b1, 1'b0, d);
  endtask

  task automatic io_read(input logic [15:0] a);
    drive(a, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic idle();
    drive(16'h0000, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);  // R7: reset state checked while held
    #1 rst_n = 1'b1;
    idle();
    scen = "R5";
    io_read(16'hCF9);           // reads zero after reset
    scen = "R4";
    io_write(16'hCF9, 8'hFB);   // bit2 clear: only bit1 kept
    io_read(16'hCF9);
    io_write(16'hCF9, 8'h00);
    io_read(16'hCF9);
    io_write(16'hCF9, 8'h02);
    scen = "R2";
    io_write(16'hCF9, 8'h04);   // trigger, type held at 1
    idle();
    scen = "R3";
    io_write(16'hCF9, 8'hFD);   // trigger with bit1 clear: type unchanged
    io_read(16'hCF9);
    scen = "R8";
    io_write(16'hCF9, 8'h06);   // back-to-back triggers
    io_write(16'hCF9, 8'h04);
    idle();
    idle();
    scen = "R1";
    io_write(16'hCF8, 8'h00);
    io_write(16'hCFA, 8'h04);
    io_write(16'h1CF9, 8'h00);  // alias on upper bit
    io_write(16'h0CF1, 8'h04);
    io_read(16'hCF9);
    scen = "R6";
    io_read(16'hCF8);
    io_read(16'h8CF9);
    drive(16'hCF9, 1'b0, 1'b0, 8'h00);
    scen = "R9";
    io_write(16'hCF9, 8'h00);
    io_write(16'hCF9, 8'h02);
    idle();
    scen = "R7";
    #1 rst_n = 1'b0;            // mid-run reset
    idle();
    idle();
    #1 rst_n = 1'b1;
    io_read(16'hCF9);
    io_write(16'hCF9, 8'h04);
    idle();
    idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule